// File: doc/BRIEF.md
# Lane-Parallel Shift-Right-and-Insert Unit

This unit takes a 128-bit source vector and a 128-bit destination vector and cuts both into equal lanes of 8, 16, 32 or 64 bits. Each source lane is shifted right logically by an immediate amount. The shifted value is then merged into the matching destination lane. Each merged lane keeps the destination's top bits, as many as the shift amount, and takes every lower bit from the shifted source. No bit moves from one lane into another.

A mode input chooses the width of the operation. In the 128-bit mode every lane is processed. In the 64-bit mode only the lower half is processed and the upper half of the destination is passed through unchanged. A small control stage decodes the lane-size code and limits the shift amount. A registered datapath produces the result one clock after a valid request, and holds that result until the next request.

Top module: `sri_unit`

## Requirements
- R1: The lane-size code `laneSize` selects the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. Every lane of one operation has the same width, and signed and unsigned data are treated the same way.
- R2: Each source lane is shifted right logically on its own. Zeros enter at the lane's top. Bits that leave the lane's low end are lost, and no bit crosses a lane boundary.
- R3: Each result lane equals (destination AND NOT mask) OR (shifted source), where the mask is an all-ones lane shifted right by the shift amount. As a result, the top `shiftAmt` bits of the destination lane survive.
- R4: A shift of 0 gives an all-ones mask, so the result lane equals the source lane.
- R5: A shift equal to or larger than the lane width gives an all-zero mask, so the result lane equals the destination lane.
- R6: With `quadMode`=1 all 128 bits are processed. With `quadMode`=0 only bits 63:0 are processed, and bits 127:64 of the result equal bits 127:64 of `dstVec`.
- R7: `outValid` is high exactly in the cycle after a cycle in which `inValid` was high. `resVec` in that cycle holds the result for the inputs sampled with that request.
- R8: While `inValid` is low, `resVec` keeps its previous value.
- R9: While `rstN` is low, `outValid` is 0 and `resVec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe; inputs are sampled when high |
| quadMode | input | 1 | 1 = 128-bit operation, 0 = lower 64 bits only |
| laneSize | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| shiftAmt | input | 7 | Right shift amount |
| srcVec | input | 128 | Source vector to be shifted |
| dstVec | input | 128 | Destination vector to be merged into |
| outValid | output | 1 | Result valid, one cycle after the request |
| resVec | output | 128 | Merged result vector |

## Verification
Some properties are checked on every clock by assertions:
- the one-cycle valid timing and the holding of the result between requests;
- the upper-half pass-through in the 64-bit mode;
- the two edge shifts: a zero shift returns the source, and a full-lane shift returns the destination;
- the one-hot lane decode and the limited shift amount.

The bit-exact merge for every in-range shift cannot be captured by a simple property. This covers keeping the destination's top bits, zero fill inside each lane, and no leakage across lanes. Only the bench's sweeps show it. The sweeps run every lane width and every shift from 0 to one past the lane width, in both modes. They use random vectors and the all-ones and all-zeros corner patterns, and they compare the result against a bit-by-bit reference.

// File: rtl/sri_pkg.sv
package sri_pkg;

  localparam int VEC_W     = 128;
  localparam int SHIFT_W   = 7;
  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE  = 8;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } laneSize_e;

  typedef struct packed {
    logic                 loadEn;
    logic                 quadEn;
    logic [NUM_SIZES-1:0] sizeHot;
    logic [SHIFT_W-1:0]   shiftLim;
  } ctrlStrobes_t;

endpackage

// File: rtl/sri_ctrl.sv
module sri_ctrl
  import sri_pkg::*;
(
  input  logic               inValid,
  input  logic               quadMode,
  input  logic [1:0]         laneSize,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output ctrlStrobes_t       strobes
);

  logic [SHIFT_W-1:0] laneWidth;

  always_comb begin
    laneWidth = SHIFT_W'(MIN_LANE << laneSize);
    strobes.loadEn  = inValid;
    strobes.quadEn  = quadMode;
    strobes.sizeHot = '0;
    strobes.sizeHot[laneSize] = 1'b1;
    // Any shift of a full lane or more gives the same all-zero mask.
    strobes.shiftLim = (shiftAmt > laneWidth) ? laneWidth : shiftAmt;
  end

endmodule

// File: rtl/sri_datapath.sv
module sri_datapath
  import sri_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstVec,
  output logic             outValid,
  output logic [VEC_W-1:0] resVec
);

  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] sizeResult [NUM_SIZES];
  logic [VEC_W-1:0] pickResult;
  logic [VEC_W-1:0] nextResult;

  // One merge network for each lane width; the control picks one of them.
  for (genvar g = 0; g < NUM_SIZES; g++) begin : gSize
    localparam int LW = MIN_LANE << g;
    localparam int NL = VEC_W / LW;
    for (genvar k = 0; k < NL; k++) begin : gLane
      logic [LW-1:0] srcLane, dstLane, shifted, keepMask;
      always_comb begin
        srcLane  = srcVec[k*LW +: LW];
        dstLane  = dstVec[k*LW +: LW];
        shifted  = srcLane >> strobes.shiftLim;
        keepMask = {LW{1'b1}} >> strobes.shiftLim;
        sizeResult[g][k*LW +: LW] = (dstLane & ~keepMask) | shifted;
      end
    end
  end

  always_comb begin
    pickResult = '0;
    for (int g = 0; g < NUM_SIZES; g++)
      if (strobes.sizeHot[g]) pickResult = pickResult | sizeResult[g];
    nextResult = strobes.quadEn ? pickResult
                                : {dstVec[VEC_W-1:HALF_W], pickResult[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      resVec   <= '0;
    end else begin
      outValid <= strobes.loadEn;
      if (strobes.loadEn) resVec <= nextResult;
    end
  end

  // R1
  size_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes.sizeHot) == 1);

  // R5
  shift_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(strobes.shiftLim) <= (MIN_LANE << (NUM_SIZES - 1)));

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> outValid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> !outValid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(resVec));

endmodule

// File: rtl/sri_unit.sv
module sri_unit
  import sri_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         quadMode,
  input  logic [1:0]   laneSize,
  input  logic [6:0]   shiftAmt,
  input  logic [127:0] srcVec,
  input  logic [127:0] dstVec,
  output logic         outValid,
  output logic [127:0] resVec
);

  localparam int HALF_W = VEC_W / 2;

  ctrlStrobes_t strobes;

  sri_ctrl ctrl_i (
    .inValid  (inValid),
    .quadMode (quadMode),
    .laneSize (laneSize),
    .shiftAmt (shiftAmt),
    .strobes  (strobes)
  );

  sri_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .srcVec   (srcVec),
    .dstVec   (dstVec),
    .outValid (outValid),
    .resVec   (resVec)
  );

  // R6
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !quadMode) |=> resVec[VEC_W-1:HALF_W] == $past(dstVec[VEC_W-1:HALF_W]));

  // R4
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && quadMode && shiftAmt == '0) |=> resVec == $past(srcVec));

  // R5
  full_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && quadMode && int'(shiftAmt) >= (MIN_LANE << laneSize)) |=> resVec == $past(dstVec));

endmodule

// File: tb/sri_unit_tb.sv
module sri_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         quadMode = 1'b0;
  logic [1:0]   laneSize = '0;
  logic [6:0]   shiftAmt = '0;
  logic [127:0] srcVec = '0;
  logic [127:0] dstVec = '0;
  logic         outValid;
  logic [127:0] resVec;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit           expValid = 1'b0;
  logic [127:0] expRes = '0;
  string        expLowTag = "";
  string        expHighTag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  sri_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .quadMode(quadMode),
    .laneSize(laneSize), .shiftAmt(shiftAmt), .srcVec(srcVec), .dstVec(dstVec),
    .outValid(outValid), .resVec(resVec)
  );

  function automatic logic [127:0] refModel(input logic [127:0] s, input logic [127:0] d,
                                            input int sizeCode, input int sh, input bit quad);
    logic [127:0] r;
    int w;
    w = 8 << sizeCode;
    for (int b = 0; b < 128; b++) begin
      int pos;
      pos = b % w;
      if (!quad && b >= 64) r[b] = d[b];
      else if (sh >= w) r[b] = d[b];
      else if (pos >= w - sh) r[b] = d[b];
      else r[b] = s[b + sh];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareOutputs();
    check("R7 outValid", {127'd0, outValid}, {127'd0, expValid});
    if (expValid) begin
      check(expLowTag, {64'd0, resVec[63:0]}, {64'd0, expRes[63:0]});
      check(expHighTag, {64'd0, resVec[127:64]}, {64'd0, expRes[127:64]});
    end else begin
      check("R8 hold", resVec, expRes);
    end
  endtask

  task automatic cycle(input bit v, input bit q, input int sz, input int sh,
                       input logic [127:0] s, input logic [127:0] d);
    @(negedge clk);
    compareOutputs();
    inValid  = v;
    quadMode = q;
    laneSize = 2'(sz);
    shiftAmt = 7'(sh);
    srcVec   = s;
    dstVec   = d;
    expValid = v;
    if (v) begin
      int w;
      w = 8 << sz;
      expRes = refModel(s, d, sz, sh, q);
      if (sh == 0) expLowTag = $sformatf("R1 R4 lane%0d shift0", w);
      else if (sh >= w) expLowTag = $sformatf("R1 R5 lane%0d shift%0d", w, sh);
      else expLowTag = $sformatf("R1 R2 R3 lane%0d shift%0d", w, sh);
      expHighTag = q ? $sformatf("R3 upper lane%0d shift%0d", w, sh)
                     : "R6 upper passthrough";
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      // R9
      check("R9 reset outValid", {127'd0, outValid}, 128'd0);
      check("R9 reset resVec", resVec, 128'd0);
    end
    rstN = 1'b1;
    for (int q = 0; q < 2; q++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int sh = 0; sh <= (8 << sz) + 1; sh++) begin
          for (int p = 0; p < 3; p++) begin
            logic [127:0] s, d;
            case (p)
              0: begin s = rnd128(); d = rnd128(); end
              1: begin s = '1; d = '0; end
              default: begin s = '0; d = '1; end
            endcase
            cycle(1'b1, q[0], sz, sh, s, d);
          end
        end
        // idle cycles with changing inputs: the result must hold
        cycle(1'b0, q[0], sz, 1, rnd128(), rnd128());
        cycle(1'b0, ~q[0], 3 - sz, 3, rnd128(), rnd128());
      end
    end
    cycle(1'b0, 1'b1, 0, 0, '0, '0);
    cycle(1'b0, 1'b1, 0, 0, '0, '0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule